// File: doc/BRIEF.md
# Tagged Register Alias Table

This block is the rename table that sits in front of a set of reservation stations. It covers a small architectural register file, ten registers by default. Every register carries a data word, a producer tag and a state. The state is ENT_READY when the word is current. It is ENT_PENDING when a station that has not yet finished will deliver the word. When an instruction is renamed, two source lookups report, for each source, either a usable value or the tag of the station that will produce it. In the same cycle, the destination register is marked pending under the station tag of the renaming instruction.

Results from the functional units come back on a broadcast bus that carries a tag and a value. A pending register accepts a result only when the broadcast tag equals the tag it holds, which is the tag of its newest writer. A result from an older producer, whose register has since been renamed again, is therefore dropped. A lookup made in the same cycle as a matching broadcast forwards the broadcast value directly.

Each register entry is a two-state machine. RENAME moves ENT_READY or ENT_PENDING to ENT_PENDING and loads the new tag. CAPTURE moves ENT_PENDING to ENT_READY when the broadcast tag matches. HOLD keeps the present state in every other case. RENAME takes priority over CAPTURE.

Top module: `rat_table`

## Requirements
- R1: After reset, every register is ready and has value zero and tag zero.
- R2: A rename with `ren_valid` high and `ren_dst` below NUM_REGS makes that register pending, holding `ren_tag`, from the next cycle. Register 0 behaves like every other register.
- R3: A lookup of a ready register gives ready=1, its stored value and its stored tag. A lookup of a pending register with no matching broadcast gives ready=0, value zero and the stored tag.
- R4: A pending register whose tag equals `bc_tag` while `bc_valid` is high becomes ready with `bc_value` in the next cycle.
- R5: A broadcast whose tag differs from a pending register's stored tag leaves that register pending with its tag unchanged. This includes a register that was renamed again after the older producer was issued.
- R6: A ready register ignores every broadcast, including one whose tag equals its stored tag, and keeps its value.
- R7: When a register is renamed in the same cycle that a broadcast matches its old tag, the register stays pending under the new tag.
- R8: A lookup of a pending register in a cycle whose broadcast matches its tag gives ready=1 and `bc_value`, with the stored tag on the tag output.
- R9: A lookup reflects the table as it stood before the rename of the same cycle, so a source may name the destination register of that rename.
- R10: A rename with an index of NUM_REGS or more changes nothing. A lookup with such an index gives ready=1, value zero and tag zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | A rename is requested this cycle |
| ren_dst | input | IDX_W | Destination register of the rename |
| ren_tag | input | TAG_W | Station tag of the renaming instruction |
| src_a_idx | input | IDX_W | First source register |
| src_a_ready | output | 1 | First source holds a usable value |
| src_a_value | output | DATA_W | First source value (zero when not ready) |
| src_a_tag | output | TAG_W | Stored producer tag of the first source |
| src_b_idx | input | IDX_W | Second source register |
| src_b_ready | output | 1 | Second source holds a usable value |
| src_b_value | output | DATA_W | Second source value (zero when not ready) |
| src_b_tag | output | TAG_W | Stored producer tag of the second source |
| bc_valid | input | 1 | A result is on the broadcast bus |
| bc_tag | input | TAG_W | Tag of the broadcast result |
| bc_value | input | DATA_W | Value of the broadcast result |

## Verification
Directed sequences cover the following cases. Renaming every register in turn separates a register that went pending from one that is untouched. A broadcast of an unused tag separates tag matching from any-broadcast capture. Re-renaming a register before its first producer broadcasts separates newest-writer matching from first-writer matching. Same-cycle rename and broadcast pairs show which of the two has priority. Lookups placed in a broadcast cycle separate the bypass from a lookup that reads only stored state. Out-of-range indices are driven on both the rename and the lookup side. A long pseudo-random sweep then mixes renames, broadcasts biased toward tags that are in use, and source indices across the whole index space, and checks both lookup ports against an arithmetic model of the table in every cycle.

// File: rtl/rat_pkg.sv
package rat_pkg;
    typedef enum logic {
        ENT_READY   = 1'b0,
        ENT_PENDING = 1'b1
    } ent_state_e;

    localparam int unsigned RD_PORTS = 2;
endpackage

// File: rtl/rat_entry.sv
module rat_entry
    import rat_pkg::*;
#(
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ren_hit,
    input  logic [TAG_W-1:0]  ren_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_value,
    output logic              ent_ready,
    output logic [TAG_W-1:0]  ent_tag,
    output logic [DATA_W-1:0] ent_value
);
    ent_state_e        state_q, state_d;
    logic [TAG_W-1:0]  tag_q, tag_d;
    logic [DATA_W-1:0] val_q, val_d;
    logic              bc_match;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ENT_READY;
            tag_q   <= '0;
            val_q   <= '0;
        end else begin
            state_q <= state_d;
            tag_q   <= tag_d;
            val_q   <= val_d;
        end
    end

    // transitions: RENAME beats CAPTURE; otherwise HOLD
    always_comb begin
        state_d  = state_q;
        tag_d    = tag_q;
        val_d    = val_q;
        bc_match = bc_valid && (bc_tag == tag_q);
        unique case (state_q)
            ENT_READY: begin
                if (ren_hit) begin
                    state_d = ENT_PENDING;
                    tag_d   = ren_tag;
                end
            end
            ENT_PENDING: begin
                if (ren_hit) begin
                    tag_d = ren_tag;
                end else if (bc_match) begin
                    state_d = ENT_READY;
                    val_d   = bc_value;
                end
            end
        endcase
    end

    always_comb begin
        ent_ready = (state_q == ENT_READY);
        ent_tag   = tag_q;
        ent_value = val_q;
    end
endmodule

// File: rtl/rat_read_port.sv
module rat_read_port #(
    parameter int NUM_REGS = 10,
    parameter int IDX_W    = 4,
    parameter int TAG_W    = 4,
    parameter int DATA_W   = 16
) (
    input  logic [IDX_W-1:0]                  rd_idx,
    input  logic [NUM_REGS-1:0]               ent_ready,
    input  logic [NUM_REGS-1:0][TAG_W-1:0]    ent_tag,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]   ent_value,
    input  logic                              bc_valid,
    input  logic [TAG_W-1:0]                  bc_tag,
    input  logic [DATA_W-1:0]                 bc_value,
    output logic                              rd_ready,
    output logic [TAG_W-1:0]                  rd_tag,
    output logic [DATA_W-1:0]                 rd_value
);
    logic              sel_ready;
    logic [TAG_W-1:0]  sel_tag;
    logic [DATA_W-1:0] sel_value;

    always_comb begin
        sel_ready = 1'b1;
        sel_tag   = '0;
        sel_value = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                sel_ready = ent_ready[i];
                sel_tag   = ent_tag[i];
                sel_value = ent_value[i];
            end
        end
    end

    always_comb begin
        rd_tag = sel_tag;
        if (sel_ready) begin
            rd_ready = 1'b1;
            rd_value = sel_value;
        end else if (bc_valid && (bc_tag == sel_tag)) begin
            rd_ready = 1'b1;
            rd_value = bc_value;
        end else begin
            rd_ready = 1'b0;
            rd_value = '0;
        end
    end
endmodule

// File: rtl/rat_table.sv
module rat_table
    import rat_pkg::*;
#(
    parameter int NUM_REGS = 10,
    parameter int TAG_W    = 4,
    parameter int DATA_W   = 16,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ren_valid,
    input  logic [IDX_W-1:0]  ren_dst,
    input  logic [TAG_W-1:0]  ren_tag,
    input  logic [IDX_W-1:0]  src_a_idx,
    output logic              src_a_ready,
    output logic [DATA_W-1:0] src_a_value,
    output logic [TAG_W-1:0]  src_a_tag,
    input  logic [IDX_W-1:0]  src_b_idx,
    output logic              src_b_ready,
    output logic [DATA_W-1:0] src_b_value,
    output logic [TAG_W-1:0]  src_b_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_value
);
    logic [NUM_REGS-1:0]               ent_ready;
    logic [NUM_REGS-1:0][TAG_W-1:0]    ent_tag;
    logic [NUM_REGS-1:0][DATA_W-1:0]   ent_value;
    logic [NUM_REGS-1:0]               ren_hit;

    logic [RD_PORTS-1:0][IDX_W-1:0]    rd_idx;
    logic [RD_PORTS-1:0]               rd_ready;
    logic [RD_PORTS-1:0][TAG_W-1:0]    rd_tag;
    logic [RD_PORTS-1:0][DATA_W-1:0]   rd_value;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_ent
        assign ren_hit[g] = ren_valid && (ren_dst == IDX_W'(g));
        rat_entry #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_ent (
            .clk       (clk),
            .rst_n     (rst_n),
            .ren_hit   (ren_hit[g]),
            .ren_tag   (ren_tag),
            .bc_valid  (bc_valid),
            .bc_tag    (bc_tag),
            .bc_value  (bc_value),
            .ent_ready (ent_ready[g]),
            .ent_tag   (ent_tag[g]),
            .ent_value (ent_value[g])
        );
    end

    assign rd_idx[0] = src_a_idx;
    assign rd_idx[1] = src_b_idx;

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        rat_read_port #(
            .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
        ) u_rd (
            .rd_idx    (rd_idx[p]),
            .ent_ready (ent_ready),
            .ent_tag   (ent_tag),
            .ent_value (ent_value),
            .bc_valid  (bc_valid),
            .bc_tag    (bc_tag),
            .bc_value  (bc_value),
            .rd_ready  (rd_ready[p]),
            .rd_tag    (rd_tag[p]),
            .rd_value  (rd_value[p])
        );
    end

    assign src_a_ready = rd_ready[0];
    assign src_a_value = rd_value[0];
    assign src_a_tag   = rd_tag[0];
    assign src_b_ready = rd_ready[1];
    assign src_b_value = rd_value[1];
    assign src_b_tag   = rd_tag[1];
endmodule

// File: rtl/rat_table_chk.sv
module rat_table_chk #(
    parameter int NUM_REGS = 10,
    parameter int TAG_W    = 4,
    parameter int DATA_W   = 16,
    parameter int IDX_W    = 4
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            ren_valid,
    input logic [IDX_W-1:0]                ren_dst,
    input logic [TAG_W-1:0]                ren_tag,
    input logic                            bc_valid,
    input logic [TAG_W-1:0]                bc_tag,
    input logic [DATA_W-1:0]               bc_value,
    input logic [NUM_REGS-1:0]             ent_ready,
    input logic [NUM_REGS-1:0][TAG_W-1:0]  ent_tag,
    input logic [NUM_REGS-1:0][DATA_W-1:0] ent_value,
    input logic                            src_a_ready,
    input logic [DATA_W-1:0]               src_a_value
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_chk
        // R2
        ren_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ren_valid && ren_dst == IDX_W'(g)) |=>
                (!ent_ready[g] && ent_tag[g] == $past(ren_tag)));

        // R4
        capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!ent_ready[g] && bc_valid && bc_tag == ent_tag[g] &&
             !(ren_valid && ren_dst == IDX_W'(g))) |=>
                (ent_ready[g] && ent_value[g] == $past(bc_value)));

        // R5
        mismatch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!ent_ready[g] && !(bc_valid && bc_tag == ent_tag[g]) &&
             !(ren_valid && ren_dst == IDX_W'(g))) |=>
                (!ent_ready[g] && $stable(ent_tag[g])));

        // R6
        ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ent_ready[g] && !(ren_valid && ren_dst == IDX_W'(g))) |=>
                (ent_ready[g] && $stable(ent_value[g])));
    end

    // R3
    pend_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !src_a_ready |-> (src_a_value == '0));
endmodule

bind rat_table rat_table_chk #(
    .NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ren_valid   (ren_valid),
    .ren_dst     (ren_dst),
    .ren_tag     (ren_tag),
    .bc_valid    (bc_valid),
    .bc_tag      (bc_tag),
    .bc_value    (bc_value),
    .ent_ready   (ent_ready),
    .ent_tag     (ent_tag),
    .ent_value   (ent_value),
    .src_a_ready (src_a_ready),
    .src_a_value (src_a_value)
);

// File: tb/rat_table_bench.sv
module rat_table_bench;
    localparam int NR = 10;
    localparam int TW = 4;
    localparam int DW = 16;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ren_valid = 1'b0;
    logic [IW-1:0] ren_dst = '0;
    logic [TW-1:0] ren_tag = '0;
    logic [IW-1:0] src_a_idx = '0;
    logic [IW-1:0] src_b_idx = '0;
    logic          bc_valid = 1'b0;
    logic [TW-1:0] bc_tag = '0;
    logic [DW-1:0] bc_value = '0;
    logic          src_a_ready, src_b_ready;
    logic [DW-1:0] src_a_value, src_b_value;
    logic [TW-1:0] src_a_tag, src_b_tag;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;
    int m_ready [NR];
    int m_tag   [NR];
    int m_val   [NR];
    logic [31:0] rs = 32'h1234_5678;

    always #10 clk = ~clk;

    rat_table #(.NUM_REGS(NR), .TAG_W(TW), .DATA_W(DW)) u_rat_table (
        .clk(clk), .rst_n(rst_n),
        .ren_valid(ren_valid), .ren_dst(ren_dst), .ren_tag(ren_tag),
        .src_a_idx(src_a_idx), .src_a_ready(src_a_ready),
        .src_a_value(src_a_value), .src_a_tag(src_a_tag),
        .src_b_idx(src_b_idx), .src_b_ready(src_b_ready),
        .src_b_value(src_b_value), .src_b_tag(src_b_tag),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_value(bc_value)
    );

    task automatic cmp(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic void look(input int idx, output int r, output int v, output int t);
        if (idx >= NR) begin
            r = 1; v = 0; t = 0;
        end else if (m_ready[idx] != 0) begin
            r = 1; v = m_val[idx]; t = m_tag[idx];
        end else if (bc_valid && int'(bc_tag) == m_tag[idx]) begin
            r = 1; v = int'(bc_value); t = m_tag[idx];
        end else begin
            r = 0; v = 0; t = m_tag[idx];
        end
    endfunction

    // inputs are set just after a falling edge; compare, then advance one cycle
    task automatic step(input string req);
        int r, v, t;
        #2;
        look(int'(src_a_idx), r, v, t);
        cmp(req, "a.ready", int'(src_a_ready), r);
        cmp(req, "a.value", int'(src_a_value), v);
        cmp(req, "a.tag",   int'(src_a_tag),   t);
        look(int'(src_b_idx), r, v, t);
        cmp(req, "b.ready", int'(src_b_ready), r);
        cmp(req, "b.value", int'(src_b_value), v);
        cmp(req, "b.tag",   int'(src_b_tag),   t);
        @(posedge clk);
        for (int i = 0; i < NR; i++) begin
            if (ren_valid && int'(ren_dst) == i) begin
                m_ready[i] = 0;
                m_tag[i]   = int'(ren_tag);
            end else if (m_ready[i] == 0 && bc_valid && int'(bc_tag) == m_tag[i]) begin
                m_ready[i] = 1;
                m_val[i]   = int'(bc_value);
            end
        end
        @(negedge clk);
    endtask

    task automatic idle();
        ren_valid = 1'b0;
        bc_valid  = 1'b0;
    endtask

    task automatic rd(input int a, input int b);
        src_a_idx = IW'(a);
        src_b_idx = IW'(b);
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NR; i++) begin
            m_ready[i] = 1; m_tag[i] = 0; m_val[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state across the whole index space (R10 above NR)
        for (int i = 0; i < 16; i++) begin
            idle(); rd(i, 15 - i);
            step("R1");
        end

        // R2 and R9: rename each register, source A names the destination
        for (int i = 0; i < NR; i++) begin
            idle();
            ren_valid = 1'b1; ren_dst = IW'(i); ren_tag = TW'(i + 1);
            rd(i, (i == 0) ? 0 : i - 1);
            step("R9");
        end
        idle();
        for (int i = 0; i < NR; i++) begin
            rd(i, NR - 1 - i);
            step("R2");
        end

        // R5: broadcast of an unused tag
        bc_valid = 1'b1; bc_tag = 4'd15; bc_value = 16'h5A5A; rd(0, 9);
        step("R5");
        idle();
        for (int i = 0; i < NR; i++) begin
            rd(i, i);
            step("R5");
        end

        // R8 then R4: register 2 waits on tag 3
        bc_valid = 1'b1; bc_tag = 4'd3; bc_value = 16'hABCD; rd(2, 1);
        step("R8");
        idle(); rd(2, 3);
        step("R4");

        // R5: register 4 renamed again before its old producer reports
        ren_valid = 1'b1; ren_dst = 4'd4; ren_tag = 4'd12; rd(4, 4);
        step("R5");
        idle();
        bc_valid = 1'b1; bc_tag = 4'd5; bc_value = 16'h0F0F; rd(3, 0);
        step("R5");
        idle(); rd(4, 4);
        step("R5");
        bc_valid = 1'b1; bc_tag = 4'd12; bc_value = 16'h7777; rd(0, 1);
        step("R4");
        idle(); rd(4, 2);
        step("R4");

        // R6: ready register 2 still holds tag 3
        bc_valid = 1'b1; bc_tag = 4'd3; bc_value = 16'h1111; rd(2, 2);
        step("R6");
        idle(); rd(2, 2);
        step("R6");

        // R7: rename of register 5 collides with its old tag 6
        ren_valid = 1'b1; ren_dst = 4'd5; ren_tag = 4'd13;
        bc_valid = 1'b1; bc_tag = 4'd6; bc_value = 16'h2222; rd(0, 1);
        step("R7");
        idle(); rd(5, 5);
        step("R7");

        // R10: out-of-range rename index
        ren_valid = 1'b1; ren_dst = 4'd11; ren_tag = 4'd9; rd(11, 12);
        step("R10");
        idle();
        for (int i = 0; i < 16; i++) begin
            rd(i, 15 - i);
            step("R10");
        end

        // R3: pseudo-random sweep over renames, broadcasts and lookups
        for (int c = 0; c < 4000; c++) begin
            rs = nxt(rs);
            ren_valid = rs[0] & rs[1];
            ren_dst   = rs[7:4];
            ren_tag   = rs[11:8];
            bc_valid  = rs[2];
            bc_tag    = rs[3] ? TW'(m_tag[int'(rs[15:12]) % NR]) : rs[15:12];
            bc_value  = rs[31:16];
            rs = nxt(rs);
            rd(int'(rs[3:0]), int'(rs[7:4]));
            step("R3");
        end
        idle();

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule